// File: doc/BRIEF.md
# Time-of-Day Alarm and Interrupt Flag Controller

This block watches a running BCD time and calendar and raises an alarm when the time matches a set of programmable alarm registers. It also keeps three event flags: the alarm, a kickstart (wake) event and a watchdog timeout. These flags drive an active-low interrupt output and an active-low power-request output. A host reads and writes the alarm settings, the flags and their enables through a byte-wide synchronous register port.

Each alarm register has a mask bit. The four mask bits, together with a day/date select bit, choose how often the alarm fires: every second, or when the seconds match, or when minutes and seconds match, or when hours, minutes and seconds match, or when a full date or day-of-week plus the time match. The comparison is made only when the once-per-second update strobe is high. Flags clear when a host read of the flag register ends. A flag that the host has not yet seen survives that clear.

Top module: `tod_alarm_ctrl`

## Requirements
- R1: The four mask bits {hr/dd reg bit 7, hours reg bit 7, minutes reg bit 7, seconds reg bit 7} form a pattern m4..m1. When m4..m1 = 1111, every update strobe sets the alarm flag. Every pattern not listed in R2 to R5 behaves the same way.
- R2: With pattern 1110, a strobe sets the alarm flag only when the seconds field matches.
- R3: With pattern 1100, a strobe sets the alarm flag only when both seconds and minutes match.
- R4: With pattern 1000, a strobe sets the alarm flag only when seconds, minutes and hours all match.
- R5: With pattern 0000, bits 5:0 of register 3 are compared along with hours, minutes and seconds. They are compared against the date when register 3 bit 6 = 0, and against the zero-extended day-of-week when that bit = 1.
- R6: The alarm comparison takes effect only on a cycle with the update strobe high. A match that persists without a strobe never sets the flag.
- R7: Each comparison uses only the value bits of its register: 7 bits for seconds (reg 0) and minutes (reg 1), and 6 bits for hours (reg 2) and day/date (reg 3). Hours bit 6 does not affect the alarm. The mask bits do not affect any comparison, and neither does the select bit.
- R8: The flag register (address 4) holds these bits: bit 0 alarm, bit 1 kickstart, bit 2 watchdog, bit 3 combined interrupt (read-only), and bit 4 power-release. The enable register (address 5) holds: bit 0 alarm interrupt enable, bit 1 kickstart enable, bit 2 watchdog enable, and bit 3 alarm-to-power enable. The combined bit equals the OR of each flag ANDed with its enable. irq_n is low exactly when the combined bit is 1.
- R9: A flag-register read clears, when the access ends, every flag the access showed. The access ends when the read strobe falls, the select falls, or the address changes. Flags never fall while the access continues.
- R10: Writing 0 to the alarm or watchdog flag clears it, and writing 1 has no effect. Writing the kickstart flag loads the written bit. A falling edge on kick_n sets the kickstart flag, and a level held low does not set it again. A wdog_fire pulse sets the watchdog flag.
- R11: The power-release bit is forced to 0 whenever the kickstart flag is 1, or when both the alarm flag and the alarm-to-power enable are 1. Otherwise the host writes it freely. pwr_on_n equals this bit.
- R12: After reset, alarm registers 0 to 3 read 0x80, the flag register reads 0x10, the enable register reads 0x00, and addresses 6 and 7 read 0x00. irq_n and pwr_on_n are both 1.
- R13: A set event in the same cycle as a clear leaves the flag set. A flag set on the cycle a read ends is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Once-per-second update strobe |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD, 24-hour |
| cur_day | input | 3 | Current day of week |
| cur_date | input | 6 | Current date of month, BCD |
| kick_n | input | 1 | Kickstart input, falling edge is an event |
| wdog_fire | input | 1 | Watchdog timeout pulse |
| bus_sel | input | 1 | Register port select |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not reading |
| irq_n | output | 1 | Interrupt, active low |
| pwr_on_n | output | 1 | Power request, 0 = active, 1 = released |

## Verification
The bench tries every mask pattern, including the illegal ones, with random alarm settings and with times that either hit or just miss. If a design decoded an illegal pattern as a real match mode, the alarm would stop firing every second. If it compared the hours spare bit or the select bit, true matches would be missed. Directed cases hold a read over several cycles and then end it by address change, by the read strobe dropping and by the select dropping. A design that cleared at the start of a read would lose flags during a long access. A design that cleared everything at the end would drop a kickstart that arrives on the closing cycle. The power-release bit is checked while the host tries to write it to 1 during a forced condition, and that write must not take effect.

// File: rtl/afc_pkg.sv
package afc_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HR_W   = 6;
    localparam int DAY_W  = 3;
    localparam int DD_W   = 6;
    localparam int N_AREG = 4;
    localparam int EN_W   = 4;

    localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;
    localparam logic [ADDR_W-1:0] A_EN   = 3'd5;
    localparam logic [DATA_W-1:0] AREG_RST = 8'h80;

    typedef enum logic [2:0] {
        AM_EVERY, AM_SEC, AM_MIN_SEC, AM_HMS, AM_DATE_HMS, AM_DAY_HMS
    } alarm_mode_e;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [MIN_W-1:0] min;
        logic [HR_W-1:0]  hr;
        logic [DAY_W-1:0] day;
        logic [DD_W-1:0]  date;
    } tod_t;

    typedef struct packed {
        logic [3:0]       mask;
        logic             day_sel;
        logic [SEC_W-1:0] sec;
        logic [MIN_W-1:0] min;
        logic [HR_W-1:0]  hr;
        logic [DD_W-1:0]  dd;
    } alarm_cfg_t;

    typedef struct packed {
        logic wdog;
        logic kick;
        logic alarm;
    } flags_t;

    typedef struct packed {
        logic pwr_en;
        logic wdog_en;
        logic kick_en;
        logic alarm_en;
    } irq_en_t;

    function automatic alarm_mode_e decode_mode(input logic [3:0] mask, input logic day_sel);
        alarm_mode_e m;
        unique case (mask)
            4'b1110: m = AM_SEC;
            4'b1100: m = AM_MIN_SEC;
            4'b1000: m = AM_HMS;
            4'b0000: m = day_sel ? AM_DAY_HMS : AM_DATE_HMS;
            default: m = AM_EVERY;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/afc_alarm_regs.sv
module afc_alarm_regs
    import afc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] areg [N_AREG],
    output alarm_cfg_t        cfg,
    output irq_en_t           en
);
    for (genvar i = 0; i < N_AREG; i++) begin : g_areg
        always_ff @(posedge clk) begin
            if (rst)
                areg[i] <= AREG_RST;
            else if (wr_en && addr == ADDR_W'(i))
                areg[i] <= wdata;
        end
        assign cfg.mask[i] = areg[i][DATA_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst)
            en <= '0;
        else if (wr_en && addr == A_EN)
            en <= irq_en_t'(wdata[EN_W-1:0]);
    end

    assign cfg.day_sel = areg[3][6];
    assign cfg.sec     = areg[0][SEC_W-1:0];
    assign cfg.min     = areg[1][MIN_W-1:0];
    assign cfg.hr      = areg[2][HR_W-1:0];
    assign cfg.dd      = areg[3][DD_W-1:0];
endmodule

// File: rtl/afc_alarm_cmp.sv
module afc_alarm_cmp
    import afc_pkg::*;
(
    input  alarm_cfg_t cfg,
    input  tod_t       tod,
    output logic       match
);
    alarm_mode_e mode;
    logic eq_sec, eq_min, eq_hr, eq_date, eq_day;

    always_comb begin
        mode    = decode_mode(cfg.mask, cfg.day_sel);
        eq_sec  = (cfg.sec == tod.sec);
        eq_min  = (cfg.min == tod.min);
        eq_hr   = (cfg.hr  == tod.hr);
        eq_date = (cfg.dd  == tod.date);
        eq_day  = (cfg.dd  == {{(DD_W-DAY_W){1'b0}}, tod.day});
        unique case (mode)
            AM_SEC:      match = eq_sec;
            AM_MIN_SEC:  match = eq_sec & eq_min;
            AM_HMS:      match = eq_sec & eq_min & eq_hr;
            AM_DATE_HMS: match = eq_sec & eq_min & eq_hr & eq_date;
            AM_DAY_HMS:  match = eq_sec & eq_min & eq_hr & eq_day;
            default:     match = 1'b1;
        endcase
    end
endmodule

// File: rtl/afc_flag_bank.sv
module afc_flag_bank
    import afc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   match,
    input  logic   kick_n,
    input  logic   wdog_fire,
    input  logic   wr_flag,
    input  logic   wd_alarm,
    input  logic   wd_kick,
    input  logic   wd_wdog,
    input  logic   wd_pab,
    input  logic   rd_active,
    input  logic   tpe,
    output flags_t flags,
    output logic   pab
);
    logic   kick_prev, rd_active_q, rd_end, force_pwr, pab_nxt;
    flags_t snap, set_v, clr_v, nxt;

    assign rd_end = rd_active_q & ~rd_active;

    always_comb begin
        set_v.alarm = tick & match;
        set_v.kick  = (kick_prev & ~kick_n) | (wr_flag & wd_kick);
        set_v.wdog  = wdog_fire;
        clr_v.alarm = (rd_end & snap.alarm) | (wr_flag & ~wd_alarm);
        clr_v.kick  = (rd_end & snap.kick)  | (wr_flag & ~wd_kick);
        clr_v.wdog  = (rd_end & snap.wdog)  | (wr_flag & ~wd_wdog);
        nxt         = flags_t'(set_v | (flags & ~clr_v));
        force_pwr   = (nxt.alarm & tpe) | nxt.kick;
        pab_nxt     = force_pwr ? 1'b0 : (wr_flag ? wd_pab : pab);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags       <= '0;
            pab         <= 1'b1;
            snap        <= '0;
            rd_active_q <= 1'b0;
            kick_prev   <= kick_n;
        end else begin
            flags       <= nxt;
            pab         <= pab_nxt;
            snap        <= rd_active ? flags_t'(snap | flags) : '0;
            rd_active_q <= rd_active;
            kick_prev   <= kick_n;
        end
    end

    assert_alarm_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.alarm) |-> $past(tick));

    assert_kick_forces_pwr_R11: assert property (@(posedge clk) disable iff (rst)
        flags.kick |-> !pab);

    assert_no_fall_midread_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_active && rd_active_q) |-> (!$fell(flags.alarm) && !$fell(flags.kick) && !$fell(flags.wdog)));

    assert_wdog_clear_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(flags.wdog) |-> $past(rd_end || wr_flag));
endmodule

// File: rtl/tod_alarm_ctrl.sv
module tod_alarm_ctrl
    import afc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HR_W-1:0]   cur_hour,
    input  logic [DAY_W-1:0]  cur_day,
    input  logic [DD_W-1:0]   cur_date,
    input  logic              kick_n,
    input  logic              wdog_fire,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_n,
    output logic              pwr_on_n
);
    logic [DATA_W-1:0] areg [N_AREG];
    alarm_cfg_t cfg;
    irq_en_t    en;
    tod_t       tod;
    flags_t     flags;
    logic       match, pab, irqf, wr_en, wr_flag, rd_flag;

    assign tod     = '{sec: cur_sec, min: cur_min, hr: cur_hour, day: cur_day, date: cur_date};
    assign wr_en   = bus_sel & bus_wr;
    assign wr_flag = wr_en & (bus_addr == A_FLAG);
    assign rd_flag = bus_sel & bus_rd & ~bus_wr & (bus_addr == A_FLAG);

    afc_alarm_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(bus_addr), .wdata(bus_wdata),
        .areg(areg), .cfg(cfg), .en(en)
    );

    afc_alarm_cmp u_cmp (.cfg(cfg), .tod(tod), .match(match));

    afc_flag_bank u_flags (
        .clk(clk), .rst(rst), .tick(tick), .match(match), .kick_n(kick_n),
        .wdog_fire(wdog_fire), .wr_flag(wr_flag),
        .wd_alarm(bus_wdata[0]), .wd_kick(bus_wdata[1]), .wd_wdog(bus_wdata[2]),
        .wd_pab(bus_wdata[4]), .rd_active(rd_flag), .tpe(en.pwr_en),
        .flags(flags), .pab(pab)
    );

    assign irqf = (flags.alarm & en.alarm_en) | (flags.kick & en.kick_en) | (flags.wdog & en.wdog_en);
    assign irq_n    = ~irqf;
    assign pwr_on_n = pab;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && bus_rd) begin
            if (bus_addr < ADDR_W'(N_AREG))
                bus_rdata = areg[bus_addr[1:0]];
            else if (bus_addr == A_FLAG)
                bus_rdata = {3'b000, pab, irqf, flags.wdog, flags.kick, flags.alarm};
            else if (bus_addr == A_EN)
                bus_rdata = {{(DATA_W-EN_W){1'b0}}, en};
        end
    end

    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (en.alarm_en == 1'b0 && en.kick_en == 1'b0 && en.wdog_en == 1'b0) |-> irq_n);
endmodule

// File: tb/tb_tod_alarm_ctrl.sv
module tb_tod_alarm_ctrl;
    logic clk = 1'b0, rst = 1'b1, tick = 1'b0, kick_n = 1'b1, wdog_fire = 1'b0;
    logic [6:0] cur_sec = '0, cur_min = '0;
    logic [5:0] cur_hour = '0, cur_date = '0;
    logic [2:0] cur_day = '0;
    logic bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic irq_n, pwr_on_n;
    int checks = 0, failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tod_alarm_ctrl dut (
        .clk(clk), .rst(rst), .tick(tick), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .cur_day(cur_day), .cur_date(cur_date), .kick_n(kick_n),
        .wdog_fire(wdog_fire), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_n(irq_n), .pwr_on_n(pwr_on_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
        @(negedge clk);
    endtask

    task automatic pulse_tick(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                              input logic [2:0] dy, input logic [5:0] dt);
        @(negedge clk);
        cur_sec = s; cur_min = m; cur_hour = h; cur_day = dy; cur_date = dt; tick = 1;
        @(negedge clk);
        tick = 0;
    endtask

    task automatic set_alarm(input logic [7:0] a0, a1, a2, a3);
        wr(0, a0); wr(1, a1); wr(2, a2); wr(3, a3);
    endtask

    function automatic bit exp_match(input logic [7:0] a0, a1, a2, a3,
                                     input logic [6:0] s, m, input logic [5:0] h,
                                     input logic [2:0] dy, input logic [5:0] dt);
        logic [3:0] pat = {a3[7], a2[7], a1[7], a0[7]};
        bit es = (a0[6:0] == s), em = (a1[6:0] == m), eh = (a2[5:0] == h);
        bit ed = (a3[5:0] == dt), ey = (a3[5:0] == {3'b000, dy});
        case (pat)
            4'b1110: return es;
            4'b1100: return es & em;
            4'b1000: return es & em & eh;
            4'b0000: return a3[6] ? (es & em & eh & ey) : (es & em & eh & ed);
            default: return 1'b1;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] pat);
        case (pat)
            4'b1110: return "R2 seconds mode";
            4'b1100: return "R3 min+sec mode";
            4'b1000: return "R4 hms mode";
            4'b0000: return "R5 day/date mode";
            default: return "R1 every-second mode";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R12 reset state
        chk("R12 irq_n", irq_n, 1);
        chk("R12 pwr_on_n", pwr_on_n, 1);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R12 reg reset", d, a < 4 ? 8'h80 : (a == 4 ? 8'h10 : 8'h00));
        end

        // R1..R5, R7 random mask patterns and near-match times
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a0, a1, a2, a3;
            logic [6:0] s, m; logic [5:0] h, dt; logic [2:0] dy;
            logic [3:0] pat;
            bit hit;
            case ($urandom_range(0, 5))
                0: pat = 4'b1111; 1: pat = 4'b1110; 2: pat = 4'b1100;
                3: pat = 4'b1000; 4: pat = 4'b0000; default: pat = 4'($urandom);
            endcase
            a0 = {pat[0], 7'($urandom_range(0, 89))};
            a1 = {pat[1], 7'($urandom_range(0, 89))};
            a2 = {pat[2], 1'($urandom), 6'($urandom_range(0, 35))};
            a3 = {pat[3], 1'($urandom), 6'($urandom_range(0, 7))};
            hit = ($urandom_range(0, 2) != 0);
            s = hit ? a0[6:0] : 7'($urandom_range(0, 89));
            m = hit ? a1[6:0] : 7'($urandom_range(0, 89));
            h = hit ? a2[5:0] : 6'($urandom_range(0, 35));
            dy = (hit && a3[6]) ? a3[2:0] : 3'($urandom);
            dt = (hit && !a3[6]) ? a3[5:0] : 6'($urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) s = s ^ 7'h01;
            set_alarm(a0, a1, a2, a3);
            wr(4, 8'h10);
            pulse_tick(s, m, h, dy, dt);
            rd(4, d);
            chk(req_of(pat), d[0], exp_match(a0, a1, a2, a3, s, m, h, dy, dt));
        end

        // R7 directed: spare hours bit, select bit and masks do not alter comparison
        set_alarm(8'h00 | 8'h30, 8'h15, 8'h40 | 8'h12, 8'h40 | 8'h05);
        wr(4, 8'h10);
        pulse_tick(7'h30, 7'h15, 6'h12, 3'd5, 6'h21);
        rd(4, d);
        chk("R7 day mode ignores spare hour bit", d[0], 1);
        set_alarm(8'h30, 8'h15, 8'h12, 8'h05);
        pulse_tick(7'h30, 7'h15, 6'h12, 3'd5, 6'h21);
        rd(4, d);
        chk("R5 date mode misses on date", d[0], 0);
        pulse_tick(7'h30, 7'h15, 6'h12, 3'd1, 6'h05);
        rd(4, d);
        chk("R5 date mode hit", d[0], 1);

        // R6 no strobe, no set
        set_alarm(8'h12, 8'h80, 8'h80, 8'h80);
        wr(4, 8'h10);
        @(negedge clk); cur_sec = 7'h12;
        repeat (5) @(negedge clk);
        rd(4, d);
        chk("R6 no set without strobe", d[0], 0);
        pulse_tick(7'h12, 7'h00, 6'h00, 3'd1, 6'h01);
        rd(4, d);
        chk("R6 set on strobe", d[0], 1);
        repeat (4) @(negedge clk);
        rd(4, d);
        chk("R6 persistent match not re-set", d[0], 0);

        // R8 interrupt combining
        set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
        wr(5, 8'h01);
        pulse_tick(7'h01, 7'h00, 6'h00, 3'd1, 6'h01);
        chk("R8 irq_n alarm enabled", irq_n, 0);
        rd(4, d);
        chk("R8 irq bit in flag reg", d[3], 1);
        chk("R8 irq_n after read clear", irq_n, 1);
        wr(5, 8'h00);
        @(negedge clk); wdog_fire = 1; @(negedge clk); wdog_fire = 0;
        chk("R8 irq_n wdog masked", irq_n, 1);
        wr(5, 8'h04);
        chk("R8 irq_n wdog enabled", irq_n, 0);
        wr(4, 8'h10);
        chk("R10 wdog write 0 clears", irq_n, 1);
        wr(5, 8'h02);
        @(negedge clk); kick_n = 0;
        @(negedge clk);
        chk("R10 kick fall sets", irq_n, 0);
        wr(4, 8'h10);
        repeat (3) @(negedge clk);
        chk("R10 held low no re-set", irq_n, 1);
        @(negedge clk); kick_n = 1;
        wr(4, 8'h12);
        chk("R10 kick write 1 sets", irq_n, 0);
        wr(4, 8'h10);
        chk("R10 kick write 0 clears", irq_n, 1);
        wr(5, 8'h00);

        // R10 write 1 does not set alarm/wdog
        wr(4, 8'h15);
        rd(4, d);
        chk("R10 write 1 no set", d[2:0], 3'b000);

        // R9 long read, end by address change
        pulse_tick(7'h02, 7'h00, 6'h00, 3'd1, 6'h01);
        @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = 4;
        #1 chk("R9 visible at start", bus_rdata[0], 1);
        @(negedge clk); #1 chk("R9 held mid-read", bus_rdata[0], 1);
        @(negedge clk); #1 chk("R9 held mid-read 2", bus_rdata[0], 1);
        @(negedge clk); bus_addr = 5;
        @(negedge clk); bus_addr = 4;
        #1 chk("R9 cleared by address change", bus_rdata[0], 0);
        @(negedge clk); bus_sel = 0; bus_rd = 0;
        @(negedge clk);
        // end by read strobe drop with select held
        pulse_tick(7'h03, 7'h00, 6'h00, 3'd1, 6'h01);
        @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = 4;
        @(negedge clk); bus_rd = 0;
        @(negedge clk); bus_rd = 1;
        #1 chk("R9 cleared by strobe drop", bus_rdata[0], 0);
        @(negedge clk); bus_sel = 0; bus_rd = 0;

        // R13 set on the closing cycle survives
        pulse_tick(7'h04, 7'h00, 6'h00, 3'd1, 6'h01);
        @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = 4;
        @(negedge clk); bus_sel = 0; bus_rd = 0; kick_n = 0; tick = 1;
        @(negedge clk); tick = 0; kick_n = 1;
        rd(4, d);
        chk("R13 alarm set wins over clear", d[0], 1);
        chk("R13 kick set at end kept", d[1], 1);

        // R11 power release bit
        wr(4, 8'h10);
        chk("R11 pwr released", pwr_on_n, 1);
        wr(4, 8'h00);
        chk("R11 pab write 0", pwr_on_n, 0);
        wr(4, 8'h10);
        chk("R11 pab write 1", pwr_on_n, 1);
        wr(5, 8'h08);
        pulse_tick(7'h05, 7'h00, 6'h00, 3'd1, 6'h01);
        chk("R11 alarm+tpe forces", pwr_on_n, 0);
        wr(4, 8'h11);
        chk("R11 write 1 ignored while forced", pwr_on_n, 0);
        wr(4, 8'h10);
        chk("R11 release after clear", pwr_on_n, 1);
        wr(5, 8'h00);
        @(negedge clk); kick_n = 0; @(negedge clk); kick_n = 1;
        chk("R11 kick forces", pwr_on_n, 0);
        rd(4, d);
        chk("R11 pab bit reads 0", d[4], 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule